// File: doc/BRIEF.md
# Serial Converter Read Controller

This block sits on the host side of a three-wire link to an 8-bit sampling converter. The link has no chip select. A one-cycle request starts a read. The controller raises the convert-start line for a timed pulse and then holds it low for the conversion time. It then drives eight serial clock pulses and captures the data line on each rising clock edge, MSB first. The assembled byte is returned with a one-cycle valid strobe.

Every timing minimum on the link is set in nanoseconds and turned into system clock cycles from the clock frequency, rounded up. The minimums cover the pulse high and low times, the conversion wait, the clock half period and the gap before the next start. The host sets the serial clock half period at run time. Values below the legal minimum are raised to that minimum. The host also picks the idle level of the clock: low for SPI mode 0, high for mode 3.

A self-test option issues a second high-low pulse on convert-start before the conversion wait begins. This makes the converter measure its internal mid-supply level instead of the input pin.

Top module: `serial_adc_reader`

## Requirements
- R1: `reqStart` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the end of the post-read gap. A request that arrives while `busy` is high has no effect on any output.
- R2: In a normal read, `adcCnvst` goes high in the cycle after acceptance. It stays high for exactly HI cycles (HI = ceil(100 ns x f)) and then stays low for the rest of the read.
- R3: With `selfTest` set, `adcCnvst` gives two pulses, each high for HI cycles, separated by LO cycles low (LO = ceil(100 ns x f)). The byte returned is the converter's mid-supply code.
- R4: The first serial clock edge comes exactly WAIT cycles after the last falling edge of `adcCnvst` (WAIT = ceil(7.5 us x f)). `adcSclk` holds its idle level during that wait.
- R5: Each read has exactly eight clock pulses. Each half period lasts H = max(`sclkHalf`, MINH) cycles, where MINH = max(ceil(75 ns x f), ceil(ceil(200 ns x f)/2)).
- R6: The idle level of `adcSclk` equals `cpol` (0 = idle low, 1 = idle high). Every pulse is a low half followed by a high half.
- R7: `adcDout` is sampled at each rising clock edge, and the first bit sampled becomes bit 7 of `dataOut`. `dataValid` is high for exactly one cycle, the first cycle after the eighth high half, with `dataOut` holding the byte.
- R8: After the eighth high half, `busy` stays high for exactly GAP cycles (GAP = ceil(50 ns x f)) before a new request can be accepted.
- R9: During reset, `adcCnvst`, `busy` and `dataValid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | One-cycle read request |
| selfTest | input | 1 | Request the mid-supply self-test channel |
| cpol | input | 1 | Serial clock idle level |
| sclkHalf | input | HALF_W | Requested serial clock half period in cycles |
| adcDout | input | 1 | Serial data from the converter |
| adcCnvst | output | 1 | Convert-start line to the converter |
| adcSclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A read is in progress |
| dataOut | output | DATA_W | Last byte read |
| dataValid | output | 1 | One-cycle strobe marking a new byte |

## Verification
At 100 MHz the bench counts t from the first cycle after acceptance. Convert-start is due high over [0,10), or also over [20,30) in self-test. The clock pulses begin at 750 cycles past the last fall. Valid is due at that start plus 16H, and busy drops 5 cycles later. A behavioural model recomputes every output level from these offsets and compares it on each falling clock edge, a half cycle away from the edge that updates the design. A converter model in the bench shifts its code out on falling clock edges and finishes its conversion before the wait expires. A read that samples too early therefore returns zeros.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE_HI,
    ST_PULSE_LO,
    ST_WAIT,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_GAP
  } rdState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;    // new read accepted
    logic sample;   // capture the data line (rising clock edge)
    logic publish;  // eighth bit done, present the byte
  } dpStrobe_t;

  // Nanoseconds to clock cycles, rounded up, never below one
  function automatic int nsToCyc(input longint ns, input longint clkKhz);
    longint c;
    c = (ns * clkKhz + 64'd999999) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_W   = 8,
  parameter int HI_CYC   = 10,
  parameter int LO_CYC   = 10,
  parameter int CONV_CYC = 750,
  parameter int MIN_HALF = 10,
  parameter int GAP_CYC  = 5,
  parameter int CNT_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              selfTest,
  input  logic              cpol,
  input  logic [HALF_W-1:0] sclkHalf,
  output logic              adcCnvst,
  output logic              adcSclk,
  output logic              busy,
  output dpStrobe_t         strobe
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rdState_t          state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  halfQ;
  logic [CNT_W-1:0]  halfPick;
  logic [BIT_W-1:0]  bitIdx;
  logic              selfTestQ;
  logic              cpolQ;
  logic              secondQ;
  logic              lastTick;

  assign lastTick = (cnt == '0);
  assign halfPick = (CNT_W'(sclkHalf) < CNT_W'(MIN_HALF)) ? CNT_W'(MIN_HALF)
                                                         : CNT_W'(sclkHalf);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      halfQ     <= '0;
      bitIdx    <= '0;
      selfTestQ <= 1'b0;
      cpolQ     <= 1'b0;
      secondQ   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqStart) begin
          state     <= ST_PULSE_HI;
          cnt       <= CNT_W'(HI_CYC - 1);
          selfTestQ <= selfTest;
          cpolQ     <= cpol;
          halfQ     <= halfPick;
          secondQ   <= 1'b0;
        end
        ST_PULSE_HI: if (lastTick) begin
          if (selfTestQ && !secondQ) begin
            state   <= ST_PULSE_LO;
            cnt     <= CNT_W'(LO_CYC - 1);
            secondQ <= 1'b1;
          end else begin
            state <= ST_WAIT;
            cnt   <= CNT_W'(CONV_CYC - 1);
          end
        end else cnt <= cnt - 1'b1;
        ST_PULSE_LO: if (lastTick) begin
          state <= ST_PULSE_HI;
          cnt   <= CNT_W'(HI_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_WAIT: if (lastTick) begin
          state  <= ST_CLK_LO;
          cnt    <= halfQ - 1'b1;
          bitIdx <= '0;
        end else cnt <= cnt - 1'b1;
        ST_CLK_LO: if (lastTick) begin
          state <= ST_CLK_HI;
          cnt   <= halfQ - 1'b1;
        end else cnt <= cnt - 1'b1;
        ST_CLK_HI: if (lastTick) begin
          if (bitIdx == LAST_BIT) begin
            state <= ST_GAP;
            cnt   <= CNT_W'(GAP_CYC - 1);
          end else begin
            state  <= ST_CLK_LO;
            cnt    <= halfQ - 1'b1;
            bitIdx <= bitIdx + 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        ST_GAP: if (lastTick) state <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state != ST_IDLE);
    adcCnvst = (state == ST_PULSE_HI);
    unique case (state)
      ST_IDLE:   adcSclk = cpol;
      ST_CLK_LO: adcSclk = 1'b0;
      ST_CLK_HI: adcSclk = 1'b1;
      default:   adcSclk = cpolQ;
    endcase
    strobe.clear   = (state == ST_IDLE) && reqStart;
    strobe.sample  = (state == ST_CLK_LO) && lastTick;
    strobe.publish = (state == ST_CLK_HI) && lastTick && (bitIdx == LAST_BIT);
  end

  // R1: settings captured at acceptance are held for the whole read
  a_r1_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE)
      |-> ($stable(cpolQ) && $stable(selfTestQ) && $stable(halfQ)));

  // R3: a second convert pulse only follows a low phase in self-test
  a_r3_second_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCnvst) && $past(state) == ST_PULSE_LO |-> selfTestQ);

endmodule

// File: rtl/adcrd_datapath.sv
module adcrd_datapath
  import adcrd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              adcDout,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  logic [DATA_W-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ    <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobe.publish;
      if (strobe.clear)
        shiftQ <= '0;
      else if (strobe.sample)
        shiftQ <= {shiftQ[DATA_W-2:0], adcDout};
      if (strobe.publish)
        dataOut <= shiftQ;
    end
  end

  // R7: the valid strobe never lasts more than one cycle
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
  import adcrd_pkg::*;
#(
  parameter int CLK_KHZ       = 100000,
  parameter int DATA_W        = 8,
  parameter int HALF_W        = 8,
  parameter int CNV_HIGH_NS   = 100,
  parameter int CNV_LOW_NS    = 100,
  parameter int CONV_NS       = 7500,
  parameter int SCLK_PULSE_NS = 75,
  parameter int SCLK_PER_NS   = 200,
  parameter int GAP_NS        = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              selfTest,
  input  logic              cpol,
  input  logic [HALF_W-1:0] sclkHalf,
  input  logic              adcDout,
  output logic              adcCnvst,
  output logic              adcSclk,
  output logic              busy,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  localparam int HI_CYC   = nsToCyc(CNV_HIGH_NS, CLK_KHZ);
  localparam int LO_CYC   = nsToCyc(CNV_LOW_NS, CLK_KHZ);
  localparam int CONV_CYC = nsToCyc(CONV_NS, CLK_KHZ);
  localparam int GAP_CYC  = nsToCyc(GAP_NS, CLK_KHZ);
  localparam int MIN_HALF = maxOf(nsToCyc(SCLK_PULSE_NS, CLK_KHZ),
                                  (nsToCyc(SCLK_PER_NS, CLK_KHZ) + 1) / 2);
  localparam int BIG_CYC  = maxOf(maxOf(HI_CYC, LO_CYC),
                                  maxOf(maxOf(CONV_CYC, GAP_CYC), MIN_HALF));
  localparam int CNT_W    = maxOf($clog2(BIG_CYC + 1), HALF_W);

  dpStrobe_t strobe;

  adcrd_ctrl #(
    .DATA_W  (DATA_W),
    .HALF_W  (HALF_W),
    .HI_CYC  (HI_CYC),
    .LO_CYC  (LO_CYC),
    .CONV_CYC(CONV_CYC),
    .MIN_HALF(MIN_HALF),
    .GAP_CYC (GAP_CYC),
    .CNT_W   (CNT_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqStart(reqStart),
    .selfTest(selfTest),
    .cpol    (cpol),
    .sclkHalf(sclkHalf),
    .adcCnvst(adcCnvst),
    .adcSclk (adcSclk),
    .busy    (busy),
    .strobe  (strobe)
  );

  adcrd_datapath #(
    .DATA_W(DATA_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .adcDout  (adcDout),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

  // R4: while a read runs, the serial clock never moves with convert-start high
  a_r4_no_clk_during_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(adcSclk)) |-> !adcCnvst);

  // R5: each capture is followed by the clock's rising edge
  a_r5_rise_after_sample: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |=> $rose(adcSclk));

  // R8: when busy drops, the link is quiet
  a_r8_quiet_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!adcCnvst && !dataValid));

endmodule

// File: tb/sim_serial_adc_reader.sv
module sim_serial_adc_reader;

  localparam int CLK_PERIOD = 10;   // 100 MHz
  localparam int HI    = 10;        // ceil(100 ns)
  localparam int LO    = 10;
  localparam int CONV  = 750;       // ceil(7.5 us)
  localparam int MINH  = 10;        // max(ceil 75 ns, ceil(200 ns)/2)
  localparam int GAP   = 5;         // ceil(50 ns)
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqStart = 1'b0;
  logic       selfTest = 1'b0;
  logic       cpol = 1'b0;
  logic [7:0] sclkHalf = 8'd10;
  logic       adcDout;
  logic       adcCnvst, adcSclk, busy, dataValid;
  logic [7:0] dataOut;

  serial_adc_reader u0 (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .selfTest(selfTest),
    .cpol(cpol), .sclkHalf(sclkHalf), .adcDout(adcDout),
    .adcCnvst(adcCnvst), .adcSclk(adcSclk), .busy(busy),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- converter model ----------------
  logic [7:0] chVal = 8'h00;
  int         cycleCnt = 0;
  logic       prevC = 1'b0, prevS = 1'b0;
  int         fallCnt = 0, rises = 0, bitPtr = 7, convEnd = 0;
  logic       readDone = 1'b1, seenRise = 1'b0;
  logic [7:0] code = 8'h00;

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    prevC <= adcCnvst;
    prevS <= adcSclk;
    if (prevC && !adcCnvst) begin
      fallCnt  <= readDone ? 1 : fallCnt + 1;
      code     <= ((readDone ? 1 : fallCnt + 1) >= 2) ? 8'h80 : chVal;
      readDone <= 1'b0;
      bitPtr   <= 7;
      seenRise <= 1'b0;
      rises    <= 0;
      convEnd  <= cycleCnt + 690;
    end else if (!readDone) begin
      if (!prevS && adcSclk) begin
        seenRise <= 1'b1;
        rises    <= rises + 1;
        if (rises == 7) readDone <= 1'b1;
      end else if (prevS && !adcSclk && seenRise && bitPtr != 0) begin
        bitPtr <= bitPtr - 1;
      end
    end
  end

  assign adcDout = (cycleCnt >= convEnd) ? code[bitPtr] : 1'b0;

  // ---------------- reference model and checks ----------------
  int   checks = 0, errors = 0, negCyc = 0;
  logic stimDone = 1'b0;
  logic active = 1'b0;
  int   t = 0, hL = 0;
  logic cpolL = 1'b0, stL = 1'b0;
  logic [7:0] expQ[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  always @(negedge clk) begin
    int p, c0, e;
    logic eC, eS, eB, eV;
    string tagS, tagB;
    negCyc++;
    if (negCyc > LIMIT) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (stimDone) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (!rstN) begin
      if (negCyc > 1) begin
        chk("R9 cnvst", adcCnvst, 0);
        chk("R9 busy", busy, 0);
        chk("R9 valid", dataValid, 0);
      end
      active = 1'b0;
    end else begin
      if (!active && reqStart) begin
        active = 1'b1;
        t      = 0;
        cpolL  = cpol;
        stL    = selfTest;
        hL     = (int'(sclkHalf) < MINH) ? MINH : int'(sclkHalf);
        expQ.push_back(selfTest ? 8'h80 : chVal);
      end
      p  = stL ? (2 * HI + LO) : HI;
      c0 = p + CONV;
      e  = c0 + 16 * hL;
      if (active && t == e + GAP) active = 1'b0;
      tagS = "R6 idle level";
      tagB = "R1 busy";
      if (active) begin
        eC = (t < HI) || (stL && t >= HI + LO && t < p);
        if (t >= c0 && t < e) begin
          eS = (((t - c0) % (2 * hL)) >= hL);
          tagS = "R5 clock pulse";
        end else begin
          eS = cpolL;
          if (t >= p && t < c0) tagS = "R4 conversion wait";
        end
        eB = 1'b1;
        eV = (t == e);
        if (t >= e) tagB = "R8 gap";
      end else begin
        eC = 1'b0; eS = cpol; eB = 1'b0; eV = 1'b0;
      end
      chk(stL ? "R3 cnvst" : "R2 cnvst", adcCnvst, eC);
      chk(tagS, adcSclk, eS);
      chk(tagB, busy, eB);
      chk("R7 valid", dataValid, eV);
      if (eV && dataValid && expQ.size() > 0)
        chk(stL ? "R3 self-test byte" : "R7 byte", dataOut, expQ.pop_front());
      if (active) t++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic runRead(input logic pol, input logic st, input logic [7:0] half,
                         input logic [7:0] val, input int pokeAt);
    @(negedge clk); #1;
    cpol = pol; selfTest = st; sclkHalf = half; chVal = val; reqStart = 1'b1;
    @(negedge clk); #1;
    reqStart = 1'b0;
    if (pokeAt > 0) begin
      repeat (pokeAt) @(negedge clk);
      #1 selfTest = 1'b1; reqStart = 1'b1;   // R1: must be ignored
      @(negedge clk); #1 reqStart = 1'b0; selfTest = st;
    end
    do @(negedge clk); while (busy);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    runRead(1'b0, 1'b0, 8'd10,  8'hA5, 0);
    runRead(1'b1, 1'b0, 8'd13,  8'h3C, 0);
    runRead(1'b0, 1'b1, 8'd10,  8'h5A, 0);
    runRead(1'b1, 1'b1, 8'd0,   8'h11, 0);
    runRead(1'b0, 1'b0, 8'd255, 8'hFF, 0);
    runRead(1'b1, 1'b0, 8'd10,  8'h00, 0);
    runRead(1'b0, 1'b0, 8'd12,  8'h96, 300);
    runRead(1'b0, 1'b0, 8'd11,  8'h01, 0);
    repeat (4) @(negedge clk);
    stimDone = 1'b1;
  end

endmodule